// File: doc/BRIEF.md
# Two-Player Number Guessing Game Controller

This block runs a two-player guessing game. The first player dials an 8-bit value on a row of switches and presses a "set" button. The value is then kept as a hidden secret. The second player dials a guess and presses a "test" button. The top LED lights when the guess equals the secret and stays dark when it does not. That result holds until the next test press. The low eight LEDs always show the live switch value, so each player can see what is dialled.

Each button first passes through a two-stage synchroniser. It then goes through a debouncer, which accepts a new level only after the level has stayed steady for a set number of clocks. Last comes a rising-edge detector, so that one press produces exactly one action. A parameter removes the debouncer for fast simulation; the synchroniser and the edge detector stay in place.

Top module: `guess_match_game`

## Requirements
- R1: After reset the stored secret is 0 and led_o[15] is 0. A test press with the switches at 0 as the first action therefore lights led_o[15].
- R2: led_o[7:0] always equals sw_i[7:0] (bit n of the LEDs follows switch n).
- R3: led_o[14:8] is always 0.
- R4: A set press stores the current sw_i value as the secret.
- R5: A test press drives led_o[15] to 1 when sw_i equals the secret and to 0 otherwise.
- R6: led_o[15] changes only on a test press. Moving the switches or pressing set leaves it unchanged.
- R7: Holding a button down causes one action only. Switch changes made while test is still held are not compared.
- R8: With debouncing enabled, a button level that lasts fewer than STABLE_CYCLES clocks has no effect. A level that lasts longer is accepted.
- R9: If set and test act in the same cycle, the comparison uses the old secret, and the new secret takes effect afterwards.
- R10: With DEBOUNCE_EN = 0, a button that is high for a single clock is enough to cause its action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sw_i | input | 8 | Switch bank: the secret or the guess |
| set_btn_i | input | 1 | Raw set button, active high, asynchronous |
| test_btn_i | input | 1 | Raw test button, active high, asynchronous |
| led_o | output | 16 | [7:0] live switches, [14:8] zero, [15] match result |

## Verification
The bench sweeps all 256 secret values. Each secret is tested once with the exact guess and once with a guess that differs in a single bit, with the flipped bit rotating through all eight positions. A stuck or miswired comparator bit is therefore caught on both the match and the mismatch side. Separate patterns cover the following cases:
- a glitch one clock shorter than the debounce window, which must be ignored;
- a long hold with the switches changing during the hold, which tells one-action-per-press apart from a level-triggered compare;
- simultaneous set and test with differing values, which reveals whether the compare saw the old secret or the new one;
- a one-clock press on a bypassed instance.

// File: rtl/guess_pkg.sv
package guess_pkg;
    localparam int NUM_BTN  = 2;
    localparam int BTN_SET  = 0;
    localparam int BTN_TEST = 1;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
    parameter int STABLE_CYCLES = 1000000,
    parameter bit DEBOUNCE_EN   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic din_i,
    output logic lvl_o
);
    localparam int CW    = $clog2(STABLE_CYCLES + 1);
    localparam int LIMIT = STABLE_CYCLES - 1;

    generate
        if (DEBOUNCE_EN) begin : g_filter
            typedef struct packed {
                logic          lvl;
                logic [CW-1:0] cnt;
            } deb_t;
            deb_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (din_i == st_q.lvl) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == CW'(LIMIT)) begin
                    st_d.lvl = din_i;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk_i) begin
                if (!rst_ni) st_q <= '0;
                else         st_q <= st_d;
            end

            assign lvl_o = st_q.lvl;

            // R8: the output level flips only after a full window of disagreement
            assert_level_after_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.lvl != $past(st_q.lvl)) |-> ($past(st_q.cnt) == CW'(LIMIT)));
        end else begin : g_bypass
            assign lvl_o = din_i;
        end
    endgenerate
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic pulse_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign pulse_o = lvl_i & ~prev_q;

    // R7: a pulse never lasts two cycles
    assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/guess_core.sv
module guess_core #(
    parameter int VAL_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [VAL_W-1:0] val_i,
    input  logic             set_pulse_i,
    input  logic             test_pulse_i,
    output logic             match_o
);
    typedef struct packed {
        logic [VAL_W-1:0] secret;
        logic             match;
    } core_t;

    core_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (test_pulse_i) st_d.match  = (val_i == st_q.secret);
        if (set_pulse_i)  st_d.secret = val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign match_o = st_q.match;

    assert_secret_loaded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_pulse_i |=> (st_q.secret == $past(val_i)));
    assert_result_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !test_pulse_i |=> $stable(match_o));
    assert_compare_old_secret_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        test_pulse_i |=> (match_o == ($past(val_i) == $past(st_q.secret))));
endmodule

// File: rtl/guess_match_game.sv
module guess_match_game #(
    parameter int SW_W          = 8,
    parameter int LED_W         = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 1000000,
    parameter bit DEBOUNCE_EN   = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SW_W-1:0]  sw_i,
    input  logic             set_btn_i,
    input  logic             test_btn_i,
    output logic [LED_W-1:0] led_o
);
    import guess_pkg::*;

    localparam int GAP_W = LED_W - SW_W - 1;

    logic [NUM_BTN-1:0] btn_raw, btn_sync, btn_lvl, btn_pulse;
    logic               match;

    always_comb begin
        btn_raw           = '0;
        btn_raw[BTN_SET]  = set_btn_i;
        btn_raw[BTN_TEST] = test_btn_i;
    end

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
        btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i(clk_i), .rst_ni(rst_ni), .din_i(btn_raw[i]), .dout_o(btn_sync[i]));
        btn_debounce #(.STABLE_CYCLES(STABLE_CYCLES), .DEBOUNCE_EN(DEBOUNCE_EN)) u_deb (
            .clk_i(clk_i), .rst_ni(rst_ni), .din_i(btn_sync[i]), .lvl_o(btn_lvl[i]));
        rise_pulse u_edge (
            .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(btn_lvl[i]), .pulse_o(btn_pulse[i]));
    end

    guess_core #(.VAL_W(SW_W)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .val_i       (sw_i),
        .set_pulse_i (btn_pulse[BTN_SET]),
        .test_pulse_i(btn_pulse[BTN_TEST]),
        .match_o     (match)
    );

    assign led_o = {match, {GAP_W{1'b0}}, sw_i};

    always_comb begin
        assert_led_mirror_R2: assert (!rst_ni || led_o[SW_W-1:0] == sw_i);
        assert_led_gap_zero_R3: assert (!rst_ni || led_o[LED_W-2:SW_W] == '0);
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        !rst_ni |=> !led_o[LED_W-1]);
endmodule

// File: tb/guess_match_game_bench.sv
module guess_match_game_bench;
    localparam int STABLE = 4;
    localparam int HOLD   = STABLE + 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sw = 8'h5A;
    logic        set_b = 1'b0, test_b = 1'b0;
    logic        set_r = 1'b0, test_r = 1'b0;
    logic [15:0] led, led_raw;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    guess_match_game #(.STABLE_CYCLES(STABLE), .DEBOUNCE_EN(1'b1)) u_guess_match_game (
        .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .set_btn_i(set_b), .test_btn_i(test_b), .led_o(led));
    guess_match_game #(.STABLE_CYCLES(STABLE), .DEBOUNCE_EN(1'b0)) u_guess_match_game_raw (
        .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .set_btn_i(set_r), .test_btn_i(test_r), .led_o(led_raw));

    function automatic logic [15:0] exp_led(input logic m, input logic [7:0] s);
        return {m, 7'b0, s};
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_set();
        set_b = 1'b1; wait_cyc(HOLD); set_b = 1'b0; wait_cyc(HOLD);
    endtask

    task automatic press_test();
        test_b = 1'b1; wait_cyc(HOLD); test_b = 1'b0; wait_cyc(HOLD);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        check(led, exp_led(1'b0, 8'h5A), "R1 reset state");
        check(led_raw, exp_led(1'b0, 8'h5A), "R1 reset state bypass");
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: secret is zero after reset
        sw = 8'h00; wait_cyc(1);
        press_test();
        check(led, exp_led(1'b1, 8'h00), "R1 secret zero after reset");

        // R2/R3: mirror and gap over all switch values
        for (int v = 0; v < 256; v++) begin
            sw = v[7:0]; wait_cyc(1);
            check(led, exp_led(1'b1, v[7:0]), "R2 R3 mirror and gap");
        end

        // R4/R5: exhaustive secret sweep, matching guess and one-bit-off guess
        for (int s = 0; s < 256; s++) begin
            sw = s[7:0]; wait_cyc(1);
            press_set();
            press_test();
            check(led, exp_led(1'b1, s[7:0]), "R4 R5 exact guess");
            sw = s[7:0] ^ (8'h01 << (s % 8)); wait_cyc(1);
            press_test();
            check(led, exp_led(1'b0, sw), "R5 one-bit-off guess");
        end
        // secret now 0xFF, last result 0

        // R6: switches and set leave the result alone
        sw = 8'hFF; wait_cyc(1);
        press_test();
        check(led, exp_led(1'b1, 8'hFF), "R6 setup match");
        sw = 8'h3C; wait_cyc(HOLD);
        check(led, exp_led(1'b1, 8'h3C), "R6 switches move");
        press_set();
        check(led, exp_led(1'b1, 8'h3C), "R6 set press keeps result");
        sw = 8'h11; wait_cyc(1);
        press_test();
        check(led, exp_led(1'b0, 8'h11), "R6 new secret took effect");

        // R7: long hold, switches change mid-hold
        sw = 8'h3C; wait_cyc(1);
        test_b = 1'b1; wait_cyc(HOLD);
        check(led, exp_led(1'b1, 8'h3C), "R7 action during hold");
        sw = 8'h99; wait_cyc(4 * HOLD);
        check(led, exp_led(1'b1, 8'h99), "R7 no re-compare while held");
        test_b = 1'b0; wait_cyc(HOLD);
        check(led, exp_led(1'b1, 8'h99), "R7 release no action");

        // R8: glitch one clock shorter than window
        test_b = 1'b1; wait_cyc(STABLE - 1); test_b = 1'b0; wait_cyc(HOLD);
        check(led, exp_led(1'b1, 8'h99), "R8 short test glitch ignored");
        set_b = 1'b1; wait_cyc(STABLE - 1); set_b = 1'b0; wait_cyc(HOLD);
        sw = 8'h3C; wait_cyc(1);
        press_test();
        check(led, exp_led(1'b1, 8'h3C), "R8 short set glitch ignored");

        // R9: simultaneous set and test, secret 0x3C, switches 0x77
        sw = 8'h77; wait_cyc(1);
        set_b = 1'b1; test_b = 1'b1; wait_cyc(HOLD);
        set_b = 1'b0; test_b = 1'b0; wait_cyc(HOLD);
        check(led, exp_led(1'b0, 8'h77), "R9 compare used old secret");
        press_test();
        check(led, exp_led(1'b1, 8'h77), "R9 new secret stored");

        // R10: bypass instance, one-clock presses
        sw = 8'hA5; wait_cyc(1);
        set_r = 1'b1; wait_cyc(1); set_r = 1'b0; wait_cyc(6);
        test_r = 1'b1; wait_cyc(1); test_r = 1'b0; wait_cyc(6);
        check(led_raw, exp_led(1'b1, 8'hA5), "R10 bypass one-clock match");
        sw = 8'hA4; wait_cyc(1);
        test_r = 1'b1; wait_cyc(1); test_r = 1'b0; wait_cyc(6);
        check(led_raw, exp_led(1'b0, 8'hA4), "R10 bypass one-clock mismatch");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule